// File: doc/BRIEF.md
# In-Band Repeating Code Detector

This block watches a serial receive stream, taking one bit on every cycle in which `bit_en` is high. It looks for two repeating patterns that software sets up: an activate (loop-up) code and a deactivate (loop-down) code. Both detectors share one code-length setting of 4, 5, 6 or 7 bits. A code of 1, 2 or 3 bits is handled by writing it repeated so that it fills one of the allowed lengths. For example, `001` is written as the 6-bit value `001001`.

A code is declared present once the stream has matched the pattern at any rotation for a number of consecutive code periods set in a register. It is declared absent after the same number of periods without a match. When a code becomes present, its live status bit and a sticky interrupt-status bit are set. Each interrupt-status bit is gated by its own enable, and the enabled bits are ORed into one interrupt request. The block never switches a loopback path itself: a host reads the status and acts on it.

Register map (3-bit address, 8-bit data):

| Addr | Name | Access | Contents |
|------|------|--------|----------|
| 0 | CFG | RW | [1:0] length code: 0→4, 1→5, 2→6, 3→7 bits |
| 1 | UPPAT | RW | [6:0] activate pattern, low L bits used |
| 2 | DNPAT | RW | [6:0] deactivate pattern, low L bits used |
| 3 | REPS | RW | [7:0] periods required (0 acts as 1) |
| 4 | LIVE | RO | bit0 activate live, bit1 deactivate live |
| 5 | ISTAT | W1C | bit0 activate event, bit1 deactivate event |
| 6 | IEN | RW | bit0 / bit1 enables for ISTAT |
| 7 | IREQ | RO | bit0 aggregate interrupt request |

Top module: `ibc_detect`

## Requirements
- R1: After reset, the registers read CFG=0x01, UPPAT=0x01, DNPAT=0x09, REPS=0x10, and LIVE, ISTAT, IEN and IREQ all read 0. The `irq` output is 0.
- R2: Let L be the length selected by the CFG code (0→4, 1→5, 2→6, 3→7) and T the effective REPS value. If the stream is a clean repetition of the activate pattern at any starting rotation, LIVE bit0 becomes 1 on exactly strobe number L-1+T·L counted from the last counter clear, and not one strobe earlier.
- R3: A cycle with `bit_en` low leaves the detection state unchanged, whatever the value of `bit_in`.
- R4: A single wrong bit at strobe e restarts the count. Detection then happens at strobe e+L-1+T·L.
- R5: A live bit returns to 0 after T·L consecutive strobes whose last-L-bit window is not a rotation of the pattern.
- R6: The two codes are detected independently. A stream carrying only the deactivate pattern sets LIVE bit1 and ISTAT bit1, and leaves bit0 of both at 0.
- R7: An ISTAT bit is set when its live bit goes from 0 to 1. It stays set until a write to ISTAT with a 1 in that bit position. Writing a 0 in that position has no effect.
- R8: `irq` and IREQ bit0 are 1 exactly when some ISTAT bit and its IEN bit are both 1.
- R9: Any write to CFG, UPPAT or DNPAT clears both match counters and the history fill. A new detection then needs the full L-1+T·L strobes after the write.
- R10: A REPS value of 0 behaves as a value of 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Strobe: `bit_in` is a received bit this cycle |
| bit_in | input | 1 | Serial receive data |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from `reg_addr`) |
| irq | output | 1 | Aggregate interrupt request |

## Verification
The hardest situation to reach from the ports is the exact strobe on which a match is declared or withdrawn. That strobe depends on the length, the repetition count, the rotation at which the stream starts, and where an error falls. The bench therefore resets, programs a small repetition count, and sweeps every length, several patterns and every starting rotation. It stops one strobe before the arithmetically predicted edge and again on that edge. To withdraw a detection, the stream is ended on a full period and followed by a run of ones. This guarantees that every later window has the wrong number of ones, so the release strobe is predictable.

// File: rtl/ibc_pkg.sv
`timescale 1ns/1ps
package ibc_pkg;

    localparam int MAX_LEN = 7;
    localparam int MIN_LEN = 4;
    localparam int LEN_W   = 3;
    localparam int THR_W   = 8;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 3;
    localparam int N_CODES = 2;
    localparam int CNT_W   = $clog2(((2 ** THR_W) - 1) * MAX_LEN + 1);

    typedef enum logic [1:0] {
        LEN_4 = 2'd0,
        LEN_5 = 2'd1,
        LEN_6 = 2'd2,
        LEN_7 = 2'd3
    } len_code_e;

    typedef enum logic [ADDR_W-1:0] {
        RA_CFG   = 3'd0,
        RA_UPPAT = 3'd1,
        RA_DNPAT = 3'd2,
        RA_REPS  = 3'd3,
        RA_LIVE  = 3'd4,
        RA_ISTAT = 3'd5,
        RA_IEN   = 3'd6,
        RA_IREQ  = 3'd7
    } reg_addr_e;

    typedef struct packed {
        len_code_e          len;
        logic [MAX_LEN-1:0] up_pat;
        logic [MAX_LEN-1:0] dn_pat;
        logic [THR_W-1:0]   reps;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{
        len:    LEN_5,
        up_pat: 7'b0000001,
        dn_pat: 7'b0001001,
        reps:   8'd16
    };

    function automatic logic [LEN_W-1:0] len_value(input len_code_e c);
        return LEN_W'(c) + LEN_W'(MIN_LEN);
    endfunction

    function automatic logic [MAX_LEN-1:0] len_mask(input logic [LEN_W-1:0] l);
        logic [MAX_LEN-1:0] m;
        for (int i = 0; i < MAX_LEN; i++) m[i] = (i < int'(l));
        return m;
    endfunction

    // rotate the low l bits of p left by r positions
    function automatic logic [MAX_LEN-1:0] rot_left(input logic [MAX_LEN-1:0] p,
                                                    input int r,
                                                    input logic [LEN_W-1:0] l);
        logic [MAX_LEN-1:0] o;
        int li;
        li = (int'(l) < 1) ? 1 : int'(l);
        o  = '0;
        for (int i = 0; i < MAX_LEN; i++) begin
            if (i < li) o[i] = p[(i + li - (r % li)) % li];
        end
        return o;
    endfunction

endpackage

// File: rtl/ibc_history.sv
`timescale 1ns/1ps
module ibc_history
    import ibc_pkg::*;
#(
    parameter int W = MAX_LEN
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             strobe,
    input  logic             bit_in,
    input  logic [LEN_W-1:0] len,
    output logic [W-1:0]     window,
    output logic             valid
);
    localparam int FILL_W = $clog2(W + 1);

    logic [W-2:0]      hist;
    logic [FILL_W-1:0] fill;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist <= '0;
            fill <= '0;
        end else begin
            if (strobe) hist <= {hist[W-3:0], bit_in};
            if (clr) begin
                fill <= '0;
            end else if (strobe && (fill < FILL_W'(W - 1))) begin
                fill <= fill + 1'b1;
            end
        end
    end

    // newest bit sits at position 0
    assign window = {hist, bit_in};
    assign valid  = (fill >= (FILL_W'(len) - 1'b1));

    a_r3_hist_hold: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> $stable(hist));

endmodule

// File: rtl/ibc_matcher.sv
`timescale 1ns/1ps
module ibc_matcher
    import ibc_pkg::*;
#(
    parameter int W  = MAX_LEN,
    parameter int CW = CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             strobe,
    input  logic             valid,
    input  logic [W-1:0]     window,
    input  logic [W-1:0]     pattern,
    input  logic [LEN_W-1:0] len,
    input  logic [CW-1:0]    target,
    output logic             live,
    output logic             rise
);
    logic [W-1:0]  masked;
    logic [W-1:0]  rot_hit;
    logic          in_sync;
    logic [CW-1:0] hit_cnt;
    logic [CW-1:0] miss_cnt;
    logic [CW:0]   hit_nx;
    logic [CW:0]   miss_nx;
    logic          hit_reach;
    logic          miss_reach;
    logic          eval;

    assign masked = window & len_mask(len);

    for (genvar r = 0; r < W; r++) begin : g_rot
        assign rot_hit[r] = (LEN_W'(r) < len) &&
                            (masked == rot_left(pattern, r, len));
    end

    assign in_sync    = |rot_hit;
    assign eval       = strobe && valid && !clr;
    assign hit_nx     = {1'b0, hit_cnt} + 1'b1;
    assign miss_nx    = {1'b0, miss_cnt} + 1'b1;
    assign hit_reach  = hit_nx >= {1'b0, target};
    assign miss_reach = miss_nx >= {1'b0, target};
    assign rise       = eval && in_sync && hit_reach && !live;

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_cnt  <= '0;
            miss_cnt <= '0;
            live     <= 1'b0;
        end else if (clr) begin
            hit_cnt  <= '0;
            miss_cnt <= '0;
        end else if (eval) begin
            if (in_sync) begin
                miss_cnt <= '0;
                if (hit_cnt < target) hit_cnt <= hit_cnt + 1'b1;
                if (hit_reach) live <= 1'b1;
            end else begin
                hit_cnt <= '0;
                if (miss_cnt < target) miss_cnt <= miss_cnt + 1'b1;
                if (miss_reach) live <= 1'b0;
            end
        end
    end

    a_r2_rise_on_strobe: assert property (@(posedge clk) disable iff (rst)
        $rose(live) |-> $past(strobe && valid));

    a_r5_fall_after_miss: assert property (@(posedge clk) disable iff (rst)
        $fell(live) |-> $past(strobe && !in_sync));

    a_r9_clear_counts: assert property (@(posedge clk) disable iff (rst)
        clr |=> (hit_cnt == '0 && miss_cnt == '0));

endmodule

// File: rtl/ibc_regs.sv
`timescale 1ns/1ps
module ibc_regs
    import ibc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [N_CODES-1:0] live,
    input  logic [N_CODES-1:0] rise,
    output cfg_t              cfg,
    output logic              cfg_clr,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    logic [N_CODES-1:0] istat;
    logic [N_CODES-1:0] ien;
    logic [N_CODES-1:0] w1c;
    reg_addr_e          ra;

    assign ra      = reg_addr_e'(reg_addr);
    assign cfg_clr = reg_we && (ra == RA_CFG || ra == RA_UPPAT || ra == RA_DNPAT);
    assign w1c     = (reg_we && ra == RA_ISTAT) ? reg_wdata[N_CODES-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg   <= CFG_RESET;
            istat <= '0;
            ien   <= '0;
        end else begin
            if (reg_we) begin
                unique case (ra)
                    RA_CFG:   cfg.len    <= len_code_e'(reg_wdata[1:0]);
                    RA_UPPAT: cfg.up_pat <= reg_wdata[MAX_LEN-1:0];
                    RA_DNPAT: cfg.dn_pat <= reg_wdata[MAX_LEN-1:0];
                    RA_REPS:  cfg.reps   <= reg_wdata[THR_W-1:0];
                    RA_IEN:   ien        <= reg_wdata[N_CODES-1:0];
                    default: ;
                endcase
            end
            // a new event wins over a clear in the same cycle
            istat <= (istat & ~w1c) | rise;
        end
    end

    assign irq = |(istat & ien);

    always_comb begin
        unique case (ra)
            RA_CFG:   reg_rdata = {6'b0, cfg.len};
            RA_UPPAT: reg_rdata = {1'b0, cfg.up_pat};
            RA_DNPAT: reg_rdata = {1'b0, cfg.dn_pat};
            RA_REPS:  reg_rdata = cfg.reps;
            RA_LIVE:  reg_rdata = {6'b0, live};
            RA_ISTAT: reg_rdata = {6'b0, istat};
            RA_IEN:   reg_rdata = {6'b0, ien};
            RA_IREQ:  reg_rdata = {7'b0, irq};
            default:  reg_rdata = '0;
        endcase
    end

    a_r7_up_sticky: assert property (@(posedge clk) disable iff (rst)
        (istat[0] && !(reg_we && ra == RA_ISTAT && reg_wdata[0])) |=> istat[0]);

    a_r7_dn_sticky: assert property (@(posedge clk) disable iff (rst)
        (istat[1] && !(reg_we && ra == RA_ISTAT && reg_wdata[1])) |=> istat[1]);

    a_r7_up_set_src: assert property (@(posedge clk) disable iff (rst)
        $rose(istat[0]) |-> $past(rise[0]));

    a_r6_dn_set_src: assert property (@(posedge clk) disable iff (rst)
        $rose(istat[1]) |-> $past(rise[1]));

endmodule

// File: rtl/ibc_detect.sv
`timescale 1ns/1ps
module ibc_detect
    import ibc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  logic              bit_in,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              irq
);
    cfg_t               cfg;
    logic               cfg_clr;
    logic [LEN_W-1:0]   len;
    logic [THR_W-1:0]   reps_eff;
    logic [CNT_W-1:0]   target;
    logic [MAX_LEN-1:0] window;
    logic               valid;
    logic [MAX_LEN-1:0] pats [N_CODES];
    logic [N_CODES-1:0] live;
    logic [N_CODES-1:0] rise;

    assign len      = len_value(cfg.len);
    assign reps_eff = (cfg.reps == '0) ? THR_W'(1) : cfg.reps;
    assign target   = CNT_W'(reps_eff) * CNT_W'(len);
    assign pats[0]  = cfg.up_pat;
    assign pats[1]  = cfg.dn_pat;

    ibc_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .live      (live),
        .rise      (rise),
        .cfg       (cfg),
        .cfg_clr   (cfg_clr),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    ibc_history #(.W(MAX_LEN)) u_hist (
        .clk    (clk),
        .rst    (rst),
        .clr    (cfg_clr),
        .strobe (bit_en),
        .bit_in (bit_in),
        .len    (len),
        .window (window),
        .valid  (valid)
    );

    for (genvar c = 0; c < N_CODES; c++) begin : g_code
        ibc_matcher #(.W(MAX_LEN), .CW(CNT_W)) u_match (
            .clk     (clk),
            .rst     (rst),
            .clr     (cfg_clr),
            .strobe  (bit_en),
            .valid   (valid),
            .window  (window),
            .pattern (pats[c]),
            .len     (len),
            .target  (target),
            .live    (live[c]),
            .rise    (rise[c])
        );
    end

    a_r3_idle_live: assert property (@(posedge clk) disable iff (rst)
        (!bit_en && !reg_we) |=> $stable(live));

endmodule

// File: tb/sim_ibc_detect.sv
`timescale 1ns/1ps
module sim_ibc_detect;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_en = 1'b0;
    logic       bit_in = 1'b0;
    logic       reg_we = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    int sidx   = 0;

    always #5 clk = ~clk;

    ibc_detect u0 (
        .clk(clk), .rst(rst), .bit_en(bit_en), .bit_in(bit_in),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; bit_en = 1'b0; reg_we = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        sidx = 0;
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = 8'(d);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        @(negedge clk);
        reg_addr = 3'(a);
        #1 v = int'(reg_rdata);
    endtask

    task automatic send(input bit b);
        @(negedge clk);
        bit_en = 1'b1; bit_in = b;
        @(negedge clk);
        bit_en = 1'b0;
    endtask

    // next bit of a pattern repeated MSB first, starting at rotation r
    task automatic send_pat(input int pat, input int l, input int r, input int n);
        for (int k = 0; k < n; k++) begin
            send(pat[l - 1 - ((sidx + r) % l)]);
            sidx++;
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int v;
        int kk;
        int pats3 [3] = '{1, 3, 5};

        do_reset();
        // R1 reset state
        rd(0, v); check("R1 cfg", v, 1);
        rd(1, v); check("R1 uppat", v, 1);
        rd(2, v); check("R1 dnpat", v, 9);
        rd(3, v); check("R1 reps", v, 16);
        rd(4, v); check("R1 live", v, 0);
        rd(5, v); check("R1 istat", v, 0);
        rd(6, v); check("R1 ien", v, 0);
        rd(7, v); check("R1 ireq", v, 0);
        check("R1 irq", int'(irq), 0);

        // R2 sweep: every length, three patterns, every rotation, T=2
        for (int l = 4; l <= 7; l++) begin
            for (int p = 0; p < 3; p++) begin
                for (int r = 0; r < l; r++) begin
                    do_reset();
                    wr(3, 2);
                    wr(0, l - 4);
                    wr(1, pats3[p]);
                    kk = l - 1 + 2 * l;
                    send_pat(pats3[p], l, r, kk - 1);
                    rd(4, v); check("R2 before edge", v & 1, 0);
                    send_pat(pats3[p], l, r, 1);
                    rd(4, v); check("R2 at edge", v & 1, 1);
                end
            end
        end

        // R3 idle cycles with noise on bit_in change nothing
        do_reset();
        wr(3, 2); wr(0, 3); wr(1, 7'b0000011);
        kk = 6 + 14;
        for (int k = 0; k < kk - 1; k++) begin
            send_pat(3, 7, 2, 1);
            repeat (3) begin
                @(negedge clk); bit_in = ~bit_in;
            end
        end
        rd(4, v); check("R3 idle no advance", v & 1, 0);
        send_pat(3, 7, 2, 1);
        rd(4, v); check("R3 edge after idle", v & 1, 1);

        // R4 single error restarts the count: L=5, T=2, error at strobe 9
        do_reset();
        wr(3, 2); wr(0, 1); wr(1, 1);
        send_pat(1, 5, 0, 8);
        send(~1'(1 >> (4 - (sidx % 5)))); sidx++;
        send_pat(1, 5, 0, 22 - 9);
        rd(4, v); check("R4 before restarted edge", v & 1, 0);
        send_pat(1, 5, 0, 1);
        rd(4, v); check("R4 restarted edge", v & 1, 1);
        rd(5, v); check("R7 istat set on detect", v, 1);

        // R5 release after T*L out-of-sync strobes (stream ends on full period)
        send_pat(1, 5, 0, 2);
        for (int k = 0; k < 9; k++) send(1'b1);
        rd(4, v); check("R5 still live", v & 1, 1);
        send(1'b1);
        rd(4, v); check("R5 released", v & 1, 0);
        rd(5, v); check("R7 istat sticky after release", v, 1);

        // R8 gating by enable
        check("R8 irq without enable", int'(irq), 0);
        wr(6, 2);
        rd(7, v); check("R8 other enable only", v, 0);
        wr(6, 1);
        rd(7, v); check("R8 ireq enabled", v, 1);
        check("R8 irq enabled", int'(irq), 1);

        // R7 write-1-to-clear
        wr(5, 2);
        rd(5, v); check("R7 write 0 keeps", v, 1);
        wr(5, 1);
        rd(5, v); check("R7 write 1 clears", v, 0);
        check("R8 irq after clear", int'(irq), 0);

        // R6 deactivate code only, length 6 pattern 001001
        do_reset();
        wr(3, 2); wr(0, 2);
        kk = 5 + 12;
        send_pat(9, 6, 1, kk - 1);
        rd(4, v); check("R6 dn before edge", v, 0);
        send_pat(9, 6, 1, 1);
        rd(4, v); check("R6 dn live only", v, 2);
        rd(5, v); check("R6 dn istat only", v, 2);

        // R9 rewriting a pattern restarts detection
        do_reset();
        wr(3, 2); wr(0, 1); wr(1, 1);
        send_pat(1, 5, 3, 10);
        wr(1, 1);
        send_pat(1, 5, 3, 13);
        rd(4, v); check("R9 before edge after write", v & 1, 0);
        send_pat(1, 5, 3, 1);
        rd(4, v); check("R9 edge after write", v & 1, 1);

        // R10 REPS=0 acts as 1: L=4 edge at strobe 7
        do_reset();
        wr(3, 0); wr(0, 0); wr(1, 1);
        send_pat(1, 4, 1, 6);
        rd(4, v); check("R10 before edge", v & 1, 0);
        send_pat(1, 4, 1, 1);
        rd(4, v); check("R10 edge", v & 1, 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule